// File: doc/BRIEF.md
# Double-Buffered Audio Sample DMA

This block moves byte-wide audio samples between system memory and a serial codec. It has one playback (transmit) channel and one capture (receive) channel. Each sample travels in its own 32-bit memory word and uses only bits 23:16 of that word. Each channel has two pointers. The current pointer walks through the active block one word at a time. The next pointer holds the address of the block that follows. When the last word of a block has been moved, the channel copies the next pointer into the current pointer and raises a load flag. Software responds by writing the address of the block after that, so it always stays one block ahead in a ring of equal-sized blocks.

Software reaches the block through a small register port. The port holds a control word with a codec-enable bit and one enable bit per direction, a sticky status word cleared by writing 1, an interrupt mask, and the four pointers. Both channels share one memory port that uses a request/acknowledge handshake. The codec reset output stays low while the codec-enable bit is clear, and it stays low for a programmable number of cycles after the bit is set.

Top module: `audio_dma_top`

## Requirements
- R1: After reset every register reads zero, codec_rst_n and irq are low, and mem_req is low.
- R2: codec_rst_n is low while CTRL bit 0 (codec enable) is 0. It rises exactly HOLD_CYC cycles after the clock edge that sets that bit, and it falls as soon as the bit is cleared.
- R3: The register addresses are 0 CTRL, 1 STAT, 2 MASK, 4 TX current, 5 TX next, 6 RX current and 7 RX next. A pointer write forces the low log2(BLK_BYTES) bits to zero, and the pointer reads back the aligned value.
- R4: Each tx_req pulse while CTRL bit 1 is set causes one memory read at the TX current pointer. tx_valid then pulses for one cycle, one cycle after mem_ack, with tx_data equal to bits 23:16 of the word read. The pointer then advances by 4.
- R5: Each rx_valid pulse while CTRL bit 2 is set causes one memory write at the RX current pointer. The word written carries rx_data in bits 23:16 and zeros in all other bits.
- R6: When the word at block offset BLK_BYTES-4 completes, the current pointer takes the next pointer's value. The load flag is set in STAT: bit 0 for TX, bit 1 for RX.
- R7: If the next pointer was not written since the previous load (or since the channel was halted), the block end still reuses the old next value. It also sets a stale flag in STAT: bit 2 for TX, bit 3 for RX.
- R8: Writing 1 to a STAT bit clears it, and writing 0 leaves it unchanged. irq is the OR of the STAT bits whose MASK bits (same positions) are set.
- R9: Clearing a direction's enable bit zeroes that channel's current and next pointers and drops its pending request. Requests made while the channel is disabled produce no memory access and no tx_valid. The other channel is not affected.
- R10: mem_req stays asserted with stable mem_addr, mem_we and mem_wdata until mem_ack. mem_addr is always word aligned. When both channels are waiting, TX is granted first and both are then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| tx_req | input | 1 | Codec asks for the next playback sample |
| tx_valid | output | 1 | Playback sample present |
| tx_data | output | 8 | Playback sample |
| rx_valid | input | 1 | Capture sample present |
| rx_data | input | 8 | Capture sample |
| codec_rst_n | output | 1 | Codec reset, active low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with AW=12, BLK_BYTES=16 and HOLD_CYC=8. With those values a block is only four words long, so block ends, pointer swaps, stale reuse and the ring behaviour are all reached within a handful of samples. The short reset hold lets the bench count the exact cycle on which the codec reset is released. Memory is preloaded with nonzero bytes in the unused lanes, so that receive writes visibly clear them and transmit reads visibly ignore them.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_TX   = 2'd1,
        OWN_RX   = 2'd2
    } owner_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_MASK  = 3'd2;
    localparam logic [2:0] A_TXCUR = 3'd4;
    localparam logic [2:0] A_TXNXT = 3'd5;
    localparam logic [2:0] A_RXCUR = 3'd6;
    localparam logic [2:0] A_RXNXT = 3'd7;

    localparam int C_CODEC = 0;
    localparam int C_TX    = 1;
    localparam int C_RX    = 2;

    localparam int S_TXLD  = 0;
    localparam int S_RXLD  = 1;
    localparam int S_TXST  = 2;
    localparam int S_RXST  = 3;
    localparam int NFLAG   = 4;

endpackage

// File: rtl/audio_dma_ptr.sv
module audio_dma_ptr #(
    parameter int AW        = 16,
    parameter int BLK_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic          wr_cur,
    input  logic          wr_next,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] nxt,
    output logic          load_evt,
    output logic          stale_evt
);
    localparam int OFS_W = $clog2(BLK_BYTES);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BLK_BYTES - 4);

    typedef struct packed {
        logic [AW-1:0] cur;
        logic [AW-1:0] nxt;
        logic          fresh;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [AW-1:0] aligned;
    logic          at_end;
    logic          unused_low;

    assign unused_low = ^wdata[OFS_W-1:0];

    always_comb begin
        aligned   = {wdata[AW-1:OFS_W], {OFS_W{1'b0}}};
        at_end    = (ptr_q.cur[OFS_W-1:0] == LAST_OFS);
        ptr_d     = ptr_q;
        load_evt  = 1'b0;
        stale_evt = 1'b0;
        if (halt) begin
            ptr_d = '0;
        end else begin
            if (step) begin
                if (at_end) begin
                    ptr_d.cur   = ptr_q.nxt;
                    ptr_d.fresh = 1'b0;
                    load_evt    = 1'b1;
                    stale_evt   = !ptr_q.fresh;
                end else begin
                    ptr_d.cur = ptr_q.cur + AW'(4);
                end
            end
            if (wr_cur) begin
                ptr_d.cur = aligned;
            end
            if (wr_next) begin
                ptr_d.nxt   = aligned;
                ptr_d.fresh = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign cur = ptr_q.cur;
    assign nxt = ptr_q.nxt;

endmodule

// File: rtl/audio_dma_rstgen.sv
module audio_dma_rstgen #(
    parameter int HOLD_CYC = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic codec_rst_n
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q != HOLD) begin
            cnt_d = cnt_q + CW'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign codec_rst_n = en && (cnt_q == HOLD);

endmodule

// File: rtl/audio_dma_top.sv
module audio_dma_top
    import audio_dma_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BLK_BYTES = 4096,
    parameter int HOLD_CYC  = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          tx_req,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          codec_rst_n,
    output logic          irq
);
    typedef struct packed {
        logic [2:0]       ctrl;
        logic [NFLAG-1:0] stat;
        logic [NFLAG-1:0] mask;
        logic             tx_pend;
        logic             rx_pend;
        logic [7:0]       rx_byte;
        owner_e           owner;
        logic             req;
        logic             we;
        logic [AW-1:0]    addr;
        logic [31:0]      wdata;
        logic             tx_valid;
        logic [7:0]       tx_data;
    } top_t;

    top_t          st_d, st_q;
    logic          wr_ctrl, tx_halt, rx_halt;
    logic          tx_step, rx_step;
    logic          tx_load, tx_stale, rx_load, rx_stale;
    logic [AW-1:0] tx_cur, tx_next, rx_cur, rx_next;
    logic          tx_on, rx_on, codec_on;
    logic          unused_bits;

    assign unused_bits = ^{reg_wdata[31:AW], mem_rdata[31:24], mem_rdata[15:0]};

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign tx_halt  = wr_ctrl && st_q.ctrl[C_TX] && !reg_wdata[C_TX];
    assign rx_halt  = wr_ctrl && st_q.ctrl[C_RX] && !reg_wdata[C_RX];
    assign tx_step  = st_q.req && mem_ack && (st_q.owner == OWN_TX) && st_q.ctrl[C_TX];
    assign rx_step  = st_q.req && mem_ack && (st_q.owner == OWN_RX) && st_q.ctrl[C_RX];
    assign tx_on    = st_q.ctrl[C_TX];
    assign rx_on    = st_q.ctrl[C_RX];
    assign codec_on = st_q.ctrl[C_CODEC];

    audio_dma_ptr #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_tx_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (tx_halt),
        .wr_cur   (reg_we && (reg_addr == A_TXCUR)),
        .wr_next  (reg_we && (reg_addr == A_TXNXT)),
        .wdata    (reg_wdata[AW-1:0]),
        .step     (tx_step),
        .cur      (tx_cur),
        .nxt      (tx_next),
        .load_evt (tx_load),
        .stale_evt(tx_stale)
    );

    audio_dma_ptr #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_rx_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (rx_halt),
        .wr_cur   (reg_we && (reg_addr == A_RXCUR)),
        .wr_next  (reg_we && (reg_addr == A_RXNXT)),
        .wdata    (reg_wdata[AW-1:0]),
        .step     (rx_step),
        .cur      (rx_cur),
        .nxt      (rx_next),
        .load_evt (rx_load),
        .stale_evt(rx_stale)
    );

    audio_dma_rstgen #(.HOLD_CYC(HOLD_CYC)) u_rstgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (codec_on),
        .codec_rst_n(codec_rst_n)
    );

    always_comb begin
        st_d          = st_q;
        st_d.tx_valid = 1'b0;

        if (wr_ctrl) begin
            st_d.ctrl = reg_wdata[2:0];
        end
        if (reg_we && (reg_addr == A_MASK)) begin
            st_d.mask = reg_wdata[NFLAG-1:0];
        end
        if (reg_we && (reg_addr == A_STAT)) begin
            st_d.stat = st_q.stat & ~reg_wdata[NFLAG-1:0];
        end
        if (tx_load)  st_d.stat[S_TXLD] = 1'b1;
        if (rx_load)  st_d.stat[S_RXLD] = 1'b1;
        if (tx_stale) st_d.stat[S_TXST] = 1'b1;
        if (rx_stale) st_d.stat[S_RXST] = 1'b1;

        if (st_q.req) begin
            if (mem_ack) begin
                st_d.req   = 1'b0;
                st_d.owner = OWN_NONE;
                if (tx_step) begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_data  = mem_rdata[23:16];
                end
            end
        end else if (st_q.tx_pend) begin
            st_d.req     = 1'b1;
            st_d.we      = 1'b0;
            st_d.owner   = OWN_TX;
            st_d.addr    = tx_cur;
            st_d.tx_pend = 1'b0;
        end else if (st_q.rx_pend) begin
            st_d.req     = 1'b1;
            st_d.we      = 1'b1;
            st_d.owner   = OWN_RX;
            st_d.addr    = rx_cur;
            st_d.wdata   = {8'h00, st_q.rx_byte, 16'h0000};
            st_d.rx_pend = 1'b0;
        end

        if (tx_req && st_q.ctrl[C_TX]) begin
            st_d.tx_pend = 1'b1;
        end
        if (rx_valid && st_q.ctrl[C_RX]) begin
            st_d.rx_pend = 1'b1;
            st_d.rx_byte = rx_data;
        end
        if (!st_d.ctrl[C_TX]) st_d.tx_pend = 1'b0;
        if (!st_d.ctrl[C_RX]) st_d.rx_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {29'd0, st_q.ctrl};
            A_STAT:  reg_rdata = 32'(st_q.stat);
            A_MASK:  reg_rdata = 32'(st_q.mask);
            A_TXCUR: reg_rdata = 32'(tx_cur);
            A_TXNXT: reg_rdata = 32'(tx_next);
            A_RXCUR: reg_rdata = 32'(rx_cur);
            A_RXNXT: reg_rdata = 32'(rx_next);
            default: reg_rdata = '0;
        endcase
    end

    assign mem_req   = st_q.req;
    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
    assign tx_valid  = st_q.tx_valid;
    assign tx_data   = st_q.tx_data;
    assign irq       = |(st_q.stat & st_q.mask);

endmodule

// File: rtl/audio_dma_chk.sv
module audio_dma_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          tx_valid,
    input logic          tx_on,
    input logic          rx_on,
    input logic [AW-1:0] tx_cur,
    input logic [AW-1:0] tx_next,
    input logic [AW-1:0] rx_cur,
    input logic [AW-1:0] rx_next,
    input logic          codec_on,
    input logic          codec_rst_n
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R10

    AST_RX_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_wdata[31:24] == 8'h00) && (mem_wdata[15:0] == 16'h0000)); // R5

    AST_TXV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(mem_req && mem_ack && !mem_we)); // R4

    AST_TX_HALT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_on) |-> (tx_cur == '0) && (tx_next == '0)); // R9

    AST_RX_HALT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_on) |-> (rx_cur == '0) && (rx_next == '0)); // R9

    AST_CODEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_on |-> !codec_rst_n); // R2

endmodule

bind audio_dma_top audio_dma_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .tx_valid   (tx_valid),
    .tx_on      (tx_on),
    .rx_on      (rx_on),
    .tx_cur     (tx_cur),
    .tx_next    (tx_next),
    .rx_cur     (rx_cur),
    .rx_next    (rx_next),
    .codec_on   (codec_on),
    .codec_rst_n(codec_rst_n)
);

// File: tb/tb_audio_dma_top.sv
`timescale 1ns/1ps
module tb_audio_dma_top;
    localparam int AW  = 12;
    localparam int BLK = 16;
    localparam int RST = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          tx_req = 1'b0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          codec_rst_n, irq;

    logic [31:0] mem [0:1023];
    logic [7:0]  expq [$];
    int          checks = 0;
    int          errors = 0;
    logic        forbid_req = 1'b0;
    logic        saw_req = 1'b0;

    always #2.5 clk = ~clk;

    audio_dma_top #(.AW(AW), .BLK_BYTES(BLK), .HOLD_CYC(RST)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tx_req(tx_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_data(rx_data), .codec_rst_n(codec_rst_n), .irq(irq)
    );

    // memory model: acknowledge one cycle after a request is seen
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[AW-1:2]];
            if (mem_we) mem[mem_addr[AW-1:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin : monitor
        logic [7:0] e;
        if (tx_valid) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9 unexpected tx_valid actual %h expected none", tx_data);
            end else begin
                e = expq.pop_front();
                check("R4 tx sample byte", {24'd0, tx_data}, {24'd0, e});
            end
        end
        if (forbid_req && mem_req) saw_req = 1'b1;
    end

    function automatic logic [7:0] pat(int i);
        return i[7:0] ^ 8'h5A;
    endfunction

    task automatic wr(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic tx_one(int word);
        expq.push_back(pat(word));
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rx_one(logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int n;
        for (int i = 0; i < 1024; i++) mem[i] = {i[7:0] ^ 8'hC3, pat(i), 16'hBEEF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 codec_rst_n", {31'd0, codec_rst_n}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        rd(3'd0, v); check("R1 CTRL", v, 32'd0);
        rd(3'd4, v); check("R1 TX current", v, 32'd0);

        // R2 codec reset hold
        wr(3'd0, 32'h1);
        n = 0;
        while (!codec_rst_n && n < 100) begin @(negedge clk); n++; end
        check("R2 codec reset release cycles", n, RST);

        // R4 R6 first block
        wr(3'd2, 32'h1);
        wr(3'd4, 32'h100);
        wr(3'd5, 32'h200);
        wr(3'd0, 32'h3);
        tx_one(64);
        rd(3'd4, v); check("R4 pointer advance", v, 32'h104);
        tx_one(65); tx_one(66); tx_one(67);
        rd(3'd4, v); check("R6 tx swap to next", v, 32'h200);
        rd(3'd1, v); check("R6 tx load flag", v, 32'h1);
        check("R8 irq on unmasked flag", {31'd0, irq}, 32'd1);

        // R8 write-one-to-clear
        wr(3'd5, 32'h300);
        wr(3'd1, 32'h0);
        rd(3'd1, v); check("R8 zero write leaves flag", v, 32'h1);
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R8 one write clears flag", v, 32'h0);
        check("R8 irq drops", {31'd0, irq}, 32'd0);

        // R7 fresh then stale
        tx_one(128); tx_one(129); tx_one(130); tx_one(131);
        rd(3'd4, v); check("R6 second swap", v, 32'h300);
        rd(3'd1, v); check("R7 no stale when refreshed", v, 32'h1);
        wr(3'd1, 32'h1);
        tx_one(192); tx_one(193); tx_one(194); tx_one(195);
        rd(3'd4, v); check("R7 stale next reused", v, 32'h300);
        rd(3'd1, v); check("R7 stale flag set", v, 32'h5);
        wr(3'd1, 32'hF);

        // R5 R10 receive and priority
        wr(3'd6, 32'h080);
        wr(3'd7, 32'h0C0);
        wr(3'd0, 32'h7);
        expq.push_back(pat(192));
        @(negedge clk); tx_req = 1'b1; rx_valid = 1'b1; rx_data = 8'h11;
        @(negedge clk); tx_req = 1'b0; rx_valid = 1'b0;
        for (int k = 0; k < 10 && !mem_req; k++) @(negedge clk);
        check("R10 TX granted first", {31'd0, mem_we}, 32'd0);
        repeat (10) @(negedge clk);
        rx_one(8'h22); rx_one(8'h33); rx_one(8'h44);
        check("R5 rx word 0", mem[32], 32'h0011_0000);
        check("R5 rx word 1", mem[33], 32'h0022_0000);
        check("R5 rx word 2", mem[34], 32'h0033_0000);
        check("R5 rx word 3", mem[35], 32'h0044_0000);
        rd(3'd6, v); check("R6 rx swap to next", v, 32'h0C0);
        rd(3'd1, v); check("R6 rx load flag", v, 32'h2);
        check("R8 masked flag keeps irq low", {31'd0, irq}, 32'd0);

        // R3 alignment
        wr(3'd5, 32'h2F7);
        rd(3'd5, v); check("R3 next aligned", v, 32'h2F0);

        // R9 halt of TX only
        wr(3'd0, 32'h5);
        rd(3'd4, v); check("R9 tx current cleared", v, 32'h0);
        rd(3'd5, v); check("R9 tx next cleared", v, 32'h0);
        rd(3'd6, v); check("R9 rx pointer untouched", v, 32'h0C0);
        forbid_req = 1'b1;
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        repeat (8) @(negedge clk);
        forbid_req = 1'b0;
        check("R9 no access while disabled", {31'd0, saw_req}, 32'd0);
        rx_one(8'h55);
        check("R9 rx still running", mem[48], 32'h0055_0000);

        // R2 codec reset on clear
        wr(3'd0, 32'h4);
        check("R2 codec reset reasserted", {31'd0, codec_rst_n}, 32'd0);
        check("R4 all expected samples seen", expq.size(), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule